// File: doc/BRIEF.md
# Thermal-Aware Multi-Core Test Scheduler

This block sequences structural test across several cores that share one test bus. Each core reports a sampled temperature. At start the scheduler loads a per-core pattern budget and reads a fixed per-core bus bandwidth need. The scheduler decides every cycle which cores hold a slice of the bus and which of them may shift patterns. It uses two temperature levels for this. A core that runs into the upper level is stopped at once and parked in passive cooling. It may compete for the bus again only after it has dropped to the lower resume level.

Bandwidth is handed out from an ordered waiting list under a shared cap. A core that leaves the bus frees its share in the very cycle it leaves, so a waiting core can take that share at once, and the split test sets of different cores interleave. Each new grant pays a configurable number of idle switching cycles before patterns flow. Once every pattern budget is used up, a completion flag is raised. The two temperature levels, the bandwidth cap and the switching penalty are run-time inputs. A start with an inconsistent setting is refused and flagged.

Top module: `thermal_test_sched`

## Requirements
- R1: While a core holds the bus and its temperature is at or above cfgTl, its testEn is low in that same cycle. From the next cycle the core shows coolingFlag high and busGrant low.
- R2: A cooling core keeps coolingFlag high and testEn and busGrant low as long as its temperature stays above cfgCl. On the first cycle with temperature at or below cfgCl, it joins the tail of the waiting list at the next edge.
- R3: On an accepted start, each core with a nonzero budget and temperature below cfgTl joins the waiting list in ascending core index. A core at or above cfgTl goes to cooling first. After reset all outputs are low.
- R4: The sum of coreBw over all cores with busGrant high never exceeds cfgBl.
- R5: The bandwidth of a core that leaves the bus in a cycle, whether through overheating or finishing, counts as free for the grant decision made in that same cycle.
- R6: At most one grant is made per cycle. It goes to the earliest list entry whose temperature is below cfgTl and whose coreBw fits in the free bandwidth. Entries ahead of it that do not fit keep their places.
- R7: After busGrant rises, testEn of that core stays low for exactly cfgOvh cycles and then rises, provided the core stays below cfgTl.
- R8: Each cycle with testEn high uses up one pattern. After as many testEn cycles as the loaded budget, the core drops busGrant and is done. A core loaded with a zero budget is done at once. allDone is high when every core is done.
- R9: A start while no core is waiting, testing or cooling is refused when cfgCl is not below cfgTl, or when any coreBw exceeds cfgBl. A refused start sets cfgErr and starts nothing. An accepted start clears cfgErr.
- R10: A core that finishes cooling is placed behind every core already on the waiting list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, taken only when no schedule is in progress |
| cfgTl | input | TEMP_W | Upper temperature limit |
| cfgCl | input | TEMP_W | Resume (stop-cooling) temperature |
| cfgBl | input | BW_W | Total bus bandwidth cap |
| cfgOvh | input | OVH_W | Idle switching cycles after each grant |
| coreTemp | input | NUM_CORES*TEMP_W | Sampled temperature per core, core 0 in the low slice |
| patLoad | input | NUM_CORES*CNT_W | Pattern budget per core, loaded at start |
| coreBw | input | NUM_CORES*BW_W | Bus bandwidth needed per core |
| testEn | output | NUM_CORES | Core applies a pattern this cycle |
| busGrant | output | NUM_CORES | Core holds its bus share |
| coolingFlag | output | NUM_CORES | Core is in passive cooling |
| allDone | output | 1 | Every core has used up its budget |
| cfgErr | output | 1 | Last start request was refused |

## Verification
Two events collide in the same cycle here. One core's exit from the bus, by overheating or by running out of patterns, can coincide with a grant to a waiting core that fits only because of the share just freed. A cooling core can also finish cooling in the same cycle that the list head is removed by a grant. The bench provokes both with tight bandwidth caps, quick heating and short cooling gaps, in a directed first-fit case and in seeded random runs. Each cycle it compares the enable, grant, cooling and completion flags against a model built from the requirements.

// File: rtl/thermal_sched_pkg.sv
package thermal_sched_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_WAIT,
    CS_RUN,
    CS_COOL,
    CS_DONE
  } coreState_t;

  // per-core observations produced by the datapath
  typedef struct packed {
    logic hot;
    logic coolOk;
    logic ovhZero;
    logic cntLast;
    logic loadZero;
  } coreStat_t;

  // per-core strobes issued by the control
  typedef struct packed {
    logic dec;
    logic ovhLoad;
  } coreStrobe_t;

endpackage

// File: rtl/ts_datapath.sv
module ts_datapath
  import thermal_sched_pkg::*;
#(
  parameter int N      = 4,
  parameter int TEMP_W = 8,
  parameter int CNT_W  = 12,
  parameter int BW_W   = 4,
  parameter int OVH_W  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [TEMP_W-1:0]             cfgTl,
  input  logic [TEMP_W-1:0]             cfgCl,
  input  logic [BW_W-1:0]               cfgBl,
  input  logic [OVH_W-1:0]              cfgOvh,
  input  logic [N-1:0][TEMP_W-1:0]      tempVec,
  input  logic [N-1:0][CNT_W-1:0]       loadVec,
  input  logic [N-1:0][BW_W-1:0]        bwVec,
  input  logic                          loadAll,
  input  coreStrobe_t [N-1:0]           stb,
  output coreStat_t [N-1:0]             stat,
  output logic                          cfgOk
);

  logic [N-1:0][CNT_W-1:0] patCnt;
  logic [N-1:0][OVH_W-1:0] ovhCnt;
  logic [N-1:0]            bwOver;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patCnt <= '0;
      ovhCnt <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (loadAll)         patCnt[i] <= loadVec[i];
        else if (stb[i].dec) patCnt[i] <= patCnt[i] - 1'b1;
        if (stb[i].ovhLoad)  ovhCnt[i] <= cfgOvh;
        else if (ovhCnt[i] != '0) ovhCnt[i] <= ovhCnt[i] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_stat
    assign stat[g].hot      = tempVec[g] >= cfgTl;
    assign stat[g].coolOk   = tempVec[g] <= cfgCl;
    assign stat[g].ovhZero  = ovhCnt[g] == '0;
    assign stat[g].cntLast  = patCnt[g] == CNT_W'(1);
    assign stat[g].loadZero = loadVec[g] == '0;
    assign bwOver[g]        = bwVec[g] > cfgBl;

    // R8: the control never asks for a pattern once the budget is empty
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
      stb[g].dec |-> patCnt[g] != '0);
  end

  assign cfgOk = (cfgCl < cfgTl) && !(|bwOver);

endmodule

// File: rtl/ts_arbiter.sv
module ts_arbiter #(
  parameter int N     = 4,
  parameter int BW_W  = 4,
  parameter int SUM_W = 7,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0][IDX_W-1:0] qArr,
  input  logic [IDX_W:0]          qLen,
  input  logic [N-1:0]            blocked,
  input  logic [N-1:0][BW_W-1:0]  bwVec,
  input  logic [SUM_W-1:0]        avail,
  output logic                    grantValid,
  output logic [IDX_W-1:0]        grantPos,
  output logic [IDX_W-1:0]        grantCore
);

  logic [IDX_W-1:0] cand;

  // first entry in list order that is cool enough and fits
  always_comb begin
    grantValid = 1'b0;
    grantPos   = '0;
    grantCore  = '0;
    cand       = '0;
    for (int j = 0; j < N; j++) begin
      cand = qArr[j];
      if (!grantValid && ((IDX_W+1)'(j) < qLen) &&
          !blocked[cand] && (SUM_W'(bwVec[cand]) <= avail)) begin
        grantValid = 1'b1;
        grantPos   = IDX_W'(j);
        grantCore  = cand;
      end
    end
  end

endmodule

// File: rtl/ts_control.sv
module ts_control
  import thermal_sched_pkg::*;
#(
  parameter int N    = 4,
  parameter int BW_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [BW_W-1:0]        cfgBl,
  input  logic [N-1:0][BW_W-1:0] bwVec,
  input  coreStat_t [N-1:0]      stat,
  input  logic                   cfgOk,
  output logic                   loadAll,
  output coreStrobe_t [N-1:0]    stb,
  output logic [N-1:0]           testEn,
  output logic [N-1:0]           busGrant,
  output logic [N-1:0]           coolingFlag,
  output logic                   allDone,
  output logic                   cfgErr
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int SUM_W = BW_W + $clog2(N + 1);

  coreState_t st [N];
  coreState_t stNext [N];

  logic [N-1:0][IDX_W-1:0] qArr, qNext;
  logic [IDX_W:0]          qLen, qLenNext;
  logic [IDX_W:0]          wp;

  logic [N-1:0] leaving, appendV, hotV, busyV, doneV;
  logic         busy, startAcc;
  logic [SUM_W-1:0] used, avail, grantedSum;

  logic             grantValid;
  logic [IDX_W-1:0] grantPos, grantCore;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      testEn[i]      = (st[i] == CS_RUN) && stat[i].ovhZero && !stat[i].hot;
      busGrant[i]    = st[i] == CS_RUN;
      coolingFlag[i] = st[i] == CS_COOL;
      hotV[i]        = stat[i].hot;
      busyV[i]       = (st[i] == CS_WAIT) || (st[i] == CS_RUN) || (st[i] == CS_COOL);
      doneV[i]       = st[i] == CS_DONE;
      leaving[i]     = (st[i] == CS_RUN) &&
                       (stat[i].hot || (testEn[i] && stat[i].cntLast));
    end
  end

  assign busy     = |busyV;
  assign startAcc = start && !busy && cfgOk;
  assign allDone  = &doneV;
  assign loadAll  = startAcc;

  // bandwidth still held after this cycle's departures
  always_comb begin
    used = '0;
    for (int i = 0; i < N; i++)
      if ((st[i] == CS_RUN) && !leaving[i]) used = used + SUM_W'(bwVec[i]);
    avail = SUM_W'(cfgBl) - used;
  end

  ts_arbiter #(.N(N), .BW_W(BW_W), .SUM_W(SUM_W), .IDX_W(IDX_W)) i_arb (
    .qArr       (qArr),
    .qLen       (qLen),
    .blocked    (hotV),
    .bwVec      (bwVec),
    .avail      (avail),
    .grantValid (grantValid),
    .grantPos   (grantPos),
    .grantCore  (grantCore)
  );

  // per-core state transitions and strobes
  always_comb begin
    for (int i = 0; i < N; i++) begin
      stNext[i]      = st[i];
      appendV[i]     = 1'b0;
      stb[i].dec     = testEn[i];
      stb[i].ovhLoad = grantValid && (grantCore == IDX_W'(i));
      case (st[i])
        CS_IDLE, CS_DONE: begin
          if (startAcc) begin
            if (stat[i].loadZero)  stNext[i] = CS_DONE;
            else if (stat[i].hot)  stNext[i] = CS_COOL;
            else begin
              stNext[i]  = CS_WAIT;
              appendV[i] = 1'b1;
            end
          end
        end
        CS_WAIT: begin
          if (grantValid && (grantCore == IDX_W'(i))) stNext[i] = CS_RUN;
        end
        CS_RUN: begin
          if (stat[i].hot)                          stNext[i] = CS_COOL;
          else if (testEn[i] && stat[i].cntLast)    stNext[i] = CS_DONE;
        end
        CS_COOL: begin
          if (stat[i].coolOk) begin
            stNext[i]  = CS_WAIT;
            appendV[i] = 1'b1;
          end
        end
        default: stNext[i] = CS_IDLE;
      endcase
    end
  end

  // waiting list: drop the granted entry, then append joiners by index
  always_comb begin
    qNext = '0;
    wp    = '0;
    for (int j = 0; j < N; j++) begin
      if (((IDX_W+1)'(j) < qLen) && !(grantValid && (grantPos == IDX_W'(j)))) begin
        if (wp < (IDX_W+1)'(N)) qNext[wp[IDX_W-1:0]] = qArr[j];
        wp = wp + 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (appendV[i]) begin
        if (wp < (IDX_W+1)'(N)) qNext[wp[IDX_W-1:0]] = IDX_W'(i);
        wp = wp + 1'b1;
      end
    end
    qLenNext = wp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) st[i] <= CS_IDLE;
      qArr   <= '0;
      qLen   <= '0;
      cfgErr <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) st[i] <= stNext[i];
      qArr <= qNext;
      qLen <= qLenNext;
      if (start && !busy) cfgErr <= !cfgOk;
    end
  end

  // ---------------- checks ----------------
  logic [N-1:0] prevRun;
  always_ff @(posedge clk) begin
    if (!rstN) prevRun <= '0;
    else       prevRun <= busGrant;
  end

  always_comb begin
    grantedSum = '0;
    for (int i = 0; i < N; i++)
      if (busGrant[i]) grantedSum = grantedSum + SUM_W'(bwVec[i]);
  end

  a_r4_bw_cap: assert property (@(posedge clk) disable iff (!rstN)
    grantedSum <= SUM_W'(cfgBl));

  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busGrant & ~prevRun));

  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r2_cool_hold: assert property (@(posedge clk) disable iff (!rstN)
      (st[g] == CS_COOL && !stat[g].coolOk) |=> (st[g] == CS_COOL));
  end

endmodule

// File: rtl/thermal_test_sched.sv
module thermal_test_sched
  import thermal_sched_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TEMP_W    = 8,
  parameter int CNT_W     = 12,
  parameter int BW_W      = 4,
  parameter int OVH_W     = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [TEMP_W-1:0]             cfgTl,
  input  logic [TEMP_W-1:0]             cfgCl,
  input  logic [BW_W-1:0]               cfgBl,
  input  logic [OVH_W-1:0]              cfgOvh,
  input  logic [NUM_CORES*TEMP_W-1:0]   coreTemp,
  input  logic [NUM_CORES*CNT_W-1:0]    patLoad,
  input  logic [NUM_CORES*BW_W-1:0]     coreBw,
  output logic [NUM_CORES-1:0]          testEn,
  output logic [NUM_CORES-1:0]          busGrant,
  output logic [NUM_CORES-1:0]          coolingFlag,
  output logic                          allDone,
  output logic                          cfgErr
);

  logic [NUM_CORES-1:0][TEMP_W-1:0] tempVec;
  logic [NUM_CORES-1:0][CNT_W-1:0]  loadVec;
  logic [NUM_CORES-1:0][BW_W-1:0]   bwVec;
  coreStat_t   [NUM_CORES-1:0]      stat;
  coreStrobe_t [NUM_CORES-1:0]      stb;
  logic                             cfgOk;
  logic                             loadAll;

  assign tempVec = coreTemp;
  assign loadVec = patLoad;
  assign bwVec   = coreBw;

  ts_datapath #(
    .N(NUM_CORES), .TEMP_W(TEMP_W), .CNT_W(CNT_W), .BW_W(BW_W), .OVH_W(OVH_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgTl   (cfgTl),
    .cfgCl   (cfgCl),
    .cfgBl   (cfgBl),
    .cfgOvh  (cfgOvh),
    .tempVec (tempVec),
    .loadVec (loadVec),
    .bwVec   (bwVec),
    .loadAll (loadAll),
    .stb     (stb),
    .stat    (stat),
    .cfgOk   (cfgOk)
  );

  ts_control #(.N(NUM_CORES), .BW_W(BW_W)) i_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cfgBl       (cfgBl),
    .bwVec       (bwVec),
    .stat        (stat),
    .cfgOk       (cfgOk),
    .loadAll     (loadAll),
    .stb         (stb),
    .testEn      (testEn),
    .busGrant    (busGrant),
    .coolingFlag (coolingFlag),
    .allDone     (allDone),
    .cfgErr      (cfgErr)
  );

  // ---------------- port-level checks ----------------
  logic [NUM_CORES-1:0] prevGrant;
  always_ff @(posedge clk) begin
    if (!rstN) prevGrant <= '0;
    else       prevGrant <= busGrant;
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_port_chk
    a_r1_hot_stop: assert property (@(posedge clk) disable iff (!rstN)
      (busGrant[g] && (tempVec[g] >= cfgTl)) |=> (coolingFlag[g] && !busGrant[g]));

    a_r7_switch_gap: assert property (@(posedge clk) disable iff (!rstN)
      (busGrant[g] && !prevGrant[g] && (cfgOvh != '0)) |-> !testEn[g]);
  end

endmodule

// File: tb/test_thermal_test_sched.sv
module test_thermal_test_sched;

  localparam int N  = 4;
  localparam int TW = 8;
  localparam int CW = 12;
  localparam int BW = 4;
  localparam int OW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [TW-1:0] cfgTl = '0, cfgCl = '0;
  logic [BW-1:0] cfgBl = '0;
  logic [OW-1:0] cfgOvh = '0;
  logic [N*TW-1:0] coreTemp = '0;
  logic [N*CW-1:0] patLoad = '0;
  logic [N*BW-1:0] coreBw = '0;
  logic [N-1:0] testEn, busGrant, coolingFlag;
  logic allDone, cfgErr;

  always #2 clk = ~clk;

  thermal_test_sched #(.NUM_CORES(N), .TEMP_W(TW), .CNT_W(CW), .BW_W(BW), .OVH_W(OW))
    i_thermal_test_sched (
      .clk(clk), .rstN(rstN), .start(start), .cfgTl(cfgTl), .cfgCl(cfgCl),
      .cfgBl(cfgBl), .cfgOvh(cfgOvh), .coreTemp(coreTemp), .patLoad(patLoad),
      .coreBw(coreBw), .testEn(testEn), .busGrant(busGrant),
      .coolingFlag(coolingFlag), .allDone(allDone), .cfgErr(cfgErr));

  int total = 0, bad = 0;
  int tl, cl, bl, ovh;
  int bw[N], load[N], temp[N], rate[N];
  bit lastTe[N];
  // model: 0 idle, 1 waiting, 2 on bus, 3 cooling, 4 done
  int mSt[N], mCnt[N], mOvh[N], mQ[N];
  int mQLen, mErr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      coreTemp[i*TW +: TW] = TW'(temp[i]);
      patLoad[i*CW +: CW]  = CW'(load[i]);
      coreBw[i*BW +: BW]   = BW'(bw[i]);
    end
    cfgTl = TW'(tl); cfgCl = TW'(cl); cfgBl = BW'(bl); cfgOvh = OW'(ovh);
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mSt[i] = 0; mCnt[i] = 0; mOvh[i] = 0; mQ[i] = 0; lastTe[i] = 0;
    end
    mQLen = 0; mErr = 0;
  endtask

  function automatic bit mTest(input int i);
    return (mSt[i] == 2) && (mOvh[i] == 0) && (temp[i] < tl);
  endfunction

  task automatic modelStep(input bit st);
    bit hot[N], te[N], lv[N], app[N];
    int busy, ok, used, avail, gp, gc, nl;
    int nq[N];
    busy = 0; ok = (cl < tl); used = 0; gp = -1; gc = -1; nl = 0;
    for (int i = 0; i < N; i++) begin
      hot[i] = temp[i] >= tl;
      te[i]  = mTest(i);
      lv[i]  = (mSt[i] == 2) && (hot[i] || (te[i] && mCnt[i] == 1));
      app[i] = 0;
      if (mSt[i] >= 1 && mSt[i] <= 3) busy = 1;
      if (bw[i] > bl) ok = 0;
    end
    for (int i = 0; i < N; i++) if (mSt[i] == 2 && !lv[i]) used += bw[i];
    avail = bl - used;
    for (int j = 0; j < mQLen; j++)
      if (gp < 0 && !hot[mQ[j]] && bw[mQ[j]] <= avail) begin gp = j; gc = mQ[j]; end
    for (int i = 0; i < N; i++) begin
      case (mSt[i])
        0, 4: if (st && !busy && ok) begin
                if (load[i] == 0) mSt[i] = 4;
                else if (hot[i]) mSt[i] = 3;
                else begin mSt[i] = 1; app[i] = 1; end
              end
        1: if (gc == i) mSt[i] = 2;
        2: if (hot[i]) mSt[i] = 3; else if (te[i] && mCnt[i] == 1) mSt[i] = 4;
        3: if (temp[i] <= cl) begin mSt[i] = 1; app[i] = 1; end
        default: ;
      endcase
      if (st && !busy && ok) mCnt[i] = load[i];
      else if (te[i]) mCnt[i]--;
      if (gc == i) mOvh[i] = ovh;
      else if (mOvh[i] > 0) mOvh[i]--;
    end
    for (int j = 0; j < mQLen; j++) if (j != gp) begin nq[nl] = mQ[j]; nl++; end
    for (int i = 0; i < N; i++) if (app[i]) begin nq[nl] = i; nl++; end
    for (int j = 0; j < nl; j++) mQ[j] = nq[j];
    mQLen = nl;
    if (st && !busy) mErr = !ok;
  endtask

  task automatic cycle(input bit st);
    int nt[N];
    int eTe, eGr, eCo, eDn, sum;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      nt[i] = temp[i];
      if (lastTe[i]) nt[i] += rate[i];
      else begin
        if (nt[i] > 30) nt[i] -= 1;
        if (lastTe[(i+1)%N]) nt[i] += 1;
      end
      if (nt[i] > 250) nt[i] = 250;
    end
    for (int i = 0; i < N; i++) temp[i] = nt[i];
    start = st;
    drive();
    #1;
    eTe = 0; eGr = 0; eCo = 0; eDn = 1; sum = 0;
    for (int i = 0; i < N; i++) begin
      if (mTest(i)) eTe |= (1 << i);
      if (mSt[i] == 2) eGr |= (1 << i);
      if (mSt[i] == 3) eCo |= (1 << i);
      if (mSt[i] != 4) eDn = 0;
      if (busGrant[i]) sum += bw[i];
      if (testEn[i]) check(temp[i] < tl, "R1 testEn while hot", temp[i], tl - 1);
    end
    check(int'(testEn) == eTe, "R1 R7 R8 testEn", int'(testEn), eTe);
    check(int'(busGrant) == eGr, "R5 R6 R10 busGrant", int'(busGrant), eGr);
    check(int'(coolingFlag) == eCo, "R2 R3 coolingFlag", int'(coolingFlag), eCo);
    check(int'(allDone) == eDn, "R8 allDone", int'(allDone), eDn);
    check(int'(cfgErr) == mErr, "R9 cfgErr", int'(cfgErr), mErr);
    check(sum <= bl, "R4 bandwidth cap", sum, bl);
    for (int i = 0; i < N; i++) lastTe[i] = testEn[i];
    modelStep(st);
  endtask

  task automatic runToDone(input int limit);
    int n;
    bit fin;
    n = 0; fin = 0;
    cycle(1);
    while (!fin && n < limit) begin
      cycle(0);
      n++;
      fin = allDone;
    end
    check(fin, "R8 schedule completes", int'(fin), 1);
    repeat (3) cycle(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    tl = 90; cl = 84; bl = 8; ovh = 1;
    for (int i = 0; i < N; i++) begin
      bw[i] = 2; load[i] = 10; temp[i] = 50; rate[i] = 3;
    end
    modelReset();
    drive();
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    check(busGrant == '0 && testEn == '0 && coolingFlag == '0, "R3 reset outputs",
          int'(busGrant | testEn | coolingFlag), 0);
    check(allDone == 1'b0 && cfgErr == 1'b0, "R8 R9 reset flags",
          int'({allDone, cfgErr}), 0);
    rstN = 1'b1;

    // R9: resume level not below limit
    cl = 90;
    cycle(1); cycle(0);
    check(cfgErr == 1'b1, "R9 bad levels flagged", int'(cfgErr), 1);
    repeat (3) cycle(0);
    check(busGrant == '0, "R9 nothing started", int'(busGrant), 0);

    // R9: one core needs more than the cap
    cl = 84; bw[2] = 9;
    cycle(1); cycle(0);
    check(cfgErr == 1'b1, "R9 oversize bandwidth flagged", int'(cfgErr), 1);
    bw[2] = 2;

    // R5 R6: first fit skips a core that does not fit
    bl = 6; bw[0] = 4; bw[1] = 4; bw[2] = 2; bw[3] = 2;
    for (int i = 0; i < N; i++) temp[i] = 50;
    cycle(1); cycle(0); cycle(0); cycle(0);
    check(busGrant == 4'b0101, "R6 first fit order", int'(busGrant), 5);
    check(cfgErr == 1'b0, "R9 accepted start clears flag", int'(cfgErr), 0);
    while (!allDone) cycle(0);
    repeat (2) cycle(0);

    // R3 R8: a hot core cools first, a zero budget core is done at once
    bl = 8; ovh = 2;
    for (int i = 0; i < N; i++) begin bw[i] = 3; temp[i] = 60; end
    temp[1] = 95; load[3] = 0;
    cycle(1); cycle(0);
    check(coolingFlag[1] == 1'b1, "R3 hot core cools first", int'(coolingFlag[1]), 1);
    check(busGrant[3] == 1'b0, "R8 zero budget never granted", int'(busGrant[3]), 0);
    runToDone(4000);

    // seeded random runs mixing overheating, cooling and tight caps
    for (int r = 0; r < 10; r++) begin
      tl  = 85 + int'($urandom % 10);
      cl  = tl - 2 - int'($urandom % 7);
      bl  = 5 + int'($urandom % 10);
      ovh = int'($urandom % 4);
      for (int i = 0; i < N; i++) begin
        bw[i]   = 1 + int'($urandom % bl);
        load[i] = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 60);
        temp[i] = 60 + int'($urandom % (tl - 55));
        rate[i] = 2 + int'($urandom % 3);
      end
      runToDone(5000);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule